// File: doc/BRIEF.md
# Accumulator Machine Control Sequencer

This block is the timing and control sequencer, together with its register file, for a small 16-bit accumulator processor with a 12-bit word address space. It holds the program counter, the address register, the instruction register, a data register, the accumulator, a carry/extension flag and an indirection flag. A 4-bit step counter is decoded into sixteen one-hot timing states. A run flag stops the machine when it is cleared.

Every instruction is fetched, decoded and, when it is an indirect memory reference, resolved through one extra memory read. It then runs through a fixed micro-step schedule that ends by returning the step counter to zero. The memory port carries a word address, write data and a write strobe, and takes back read data. Read data is expected combinationally within the same cycle. A write is taken at the rising edge that ends the cycle in which the strobe is high.

Instruction word layout: bit 15 is the indirect flag, bits 14..12 are the opcode and bits 11..0 are the address. Opcode 7 with bit 15 clear is a register operation. Opcode 7 with bit 15 set is a peripheral instruction. This block does not implement peripheral instructions and simply ends them.

Top module: `acc_sequencer`

## Requirements
- R1: While reset is low, pcValue is 0, accValue is 0, eFlag is 0 and running is 1.
- R2: Each instruction is fetched from the address held in PC, and PC is then incremented. Bit 15 of the word selects indirection, bits 14..12 hold the opcode and bits 11..0 hold the address.
- R3: A memory reference with bit 15 set uses the word at its address field as the effective address. With bit 15 clear, the address field itself is the effective address.
- R4: Opcode 0 ANDs the operand into AC. Opcode 1 adds the operand to AC and puts the carry-out in E. Opcode 2 loads AC with the operand.
- R5: Opcode 3 writes AC to the effective address. The write strobe is only ever high in timing states 4 and 6.
- R6: Opcode 4 jumps to the effective address. Opcode 5 stores the return PC at the effective address and continues at the effective address + 1.
- R7: Opcode 6 increments the word at the effective address and writes it back. When the new value is zero, the next instruction is skipped. The instruction ends after timing state 6.
- R8: In a register operation, set bits of the low 12 bits take effect: bit 11 clears AC, bit 10 clears E, bit 9 inverts AC, bit 8 inverts E, bit 7 rotates {E,AC} right, bit 6 rotates {AC,E} left, and bit 5 increments AC. The instruction ends after timing state 3.
- R9: In a register operation, bit 4 skips if AC bit 15 is 0, bit 3 skips if AC bit 15 is 1, bit 2 skips if AC is zero, and bit 1 skips if E is 0.
- R10: Register-operation bit 0 clears running. After that the step counter, PC and memory stay frozen. A peripheral instruction (opcode 7, bit 15 set) changes no register or memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| memRdata | input | 16 | Word read from memory at memAddr, valid in the same cycle |
| memAddr | output | 12 | Word address, always the address register |
| memWdata | output | 16 | Data to be written |
| memWe | output | 1 | Write strobe, taken at the end of the cycle |
| accValue | output | 16 | Current accumulator |
| pcValue | output | 12 | Current program counter |
| eFlag | output | 1 | Current carry/extension flag |
| running | output | 1 | High while the machine runs |

## Verification
Skip conditions are the hardest behaviour to observe at the ports. A skip and a non-skip both leave the next instruction fetched or not, with no direct trace. The stimulus program therefore places a halt in every skipped slot, and places a visible memory store in every slot that must not be skipped. A wrong decision then shows up either as a missing or extra store in the write scoreboard or as a wrong final PC. The same approach covers the rotate chain through E: the carry from an add travels through an E inversion and a right rotate before it appears in a stored word.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 12;
  localparam int SC_W   = 4;
  localparam int N_T    = 1 << SC_W;
  localparam int OPC_LO = ADDR_W;
  localparam int OPC_W  = 3;
  localparam int IND_B  = DATA_W - 1;

  typedef enum logic [OPC_W-1:0] {
    OP_AND = 3'd0, OP_ADD = 3'd1, OP_LDA = 3'd2, OP_STA = 3'd3,
    OP_BUN = 3'd4, OP_BSA = 3'd5, OP_ISZ = 3'd6, OP_REG = 3'd7
  } opc_e;

  typedef enum logic [1:0] {WSRC_AC, WSRC_PC, WSRC_DR} wsrc_e;

  typedef struct packed {
    logic  arFromPc, arFromIr, arFromMem, arInc;
    logic  pcInc, pcFromAr, irLoad, iLoad;
    logic  drLoad, drInc;
    logic  acClr, acCmp, acShr, acShl, acInc, acAnd, acAdd, acFromDr;
    logic  eClr, eCmp, memWe;
    wsrc_e wSrc;
  } strobe_t;
endpackage

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ir,
  input  logic              iFlag,
  input  logic              acSign,
  input  logic              acZero,
  input  logic              eVal,
  input  logic              drZero,
  output strobe_t           strb,
  output logic              running
);
  logic [SC_W-1:0] sc;
  logic [N_T-1:0]  tState;
  logic            clrSc, haltReq, skip;
  opc_e            opc;

  assign tState = N_T'(1) << sc;
  assign opc    = opc_e'(ir[OPC_LO +: OPC_W]);

  always_comb begin
    strb    = '0;
    clrSc   = 1'b0;
    haltReq = 1'b0;
    skip    = 1'b0;
    if (running) begin
      if (tState[0]) strb.arFromPc = 1'b1;
      if (tState[1]) begin strb.irLoad = 1'b1; strb.pcInc = 1'b1; end
      if (tState[2]) begin strb.arFromIr = 1'b1; strb.iLoad = 1'b1; end
      if (tState[3]) begin
        if (opc == OP_REG) begin
          clrSc = 1'b1;
          if (!iFlag) begin
            strb.acClr = ir[11];
            strb.eClr  = ir[10];
            strb.acCmp = ir[9];
            strb.eCmp  = ir[8];
            strb.acShr = ir[7];
            strb.acShl = ir[6];
            strb.acInc = ir[5];
            skip = (ir[4] && !acSign) || (ir[3] && acSign) ||
                   (ir[2] && acZero)  || (ir[1] && !eVal);
            strb.pcInc = skip;
            haltReq    = ir[0];
          end
        end else if (iFlag) begin
          strb.arFromMem = 1'b1;
        end
      end
      if (tState[4]) begin
        unique case (opc)
          OP_AND, OP_ADD, OP_LDA, OP_ISZ: strb.drLoad = 1'b1;
          OP_STA: begin strb.memWe = 1'b1; strb.wSrc = WSRC_AC; clrSc = 1'b1; end
          OP_BUN: begin strb.pcFromAr = 1'b1; clrSc = 1'b1; end
          OP_BSA: begin strb.memWe = 1'b1; strb.wSrc = WSRC_PC; strb.arInc = 1'b1; end
          default: ;
        endcase
      end
      if (tState[5]) begin
        unique case (opc)
          OP_AND: begin strb.acAnd = 1'b1; clrSc = 1'b1; end
          OP_ADD: begin strb.acAdd = 1'b1; clrSc = 1'b1; end
          OP_LDA: begin strb.acFromDr = 1'b1; clrSc = 1'b1; end
          OP_BSA: begin strb.pcFromAr = 1'b1; clrSc = 1'b1; end
          OP_ISZ: strb.drInc = 1'b1;
          default: ;
        endcase
      end
      if (tState[6] && opc == OP_ISZ) begin
        strb.memWe = 1'b1;
        strb.wSrc  = WSRC_DR;
        strb.pcInc = drZero;
        clrSc      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc      <= '0;
      running <= 1'b1;
    end else if (running) begin
      sc <= clrSc ? '0 : sc + 1'b1;
      if (haltReq) running <= 1'b0;
    end
  end

  // R5: memory writes only in the execute steps that store
  p_we_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.memWe |-> (sc == 4 || sc == 6));
  // R7: no schedule runs past timing state 6
  p_max_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sc == 6) |=> (sc == 0));
  // R8: register and peripheral instructions end after state 3
  p_regop_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sc == 3 && ir[OPC_LO +: OPC_W] == 3'd7) |=> (sc == 0));
  // R10: a halted machine stays frozen
  p_halt_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (!running && $stable(sc)));
endmodule

// File: rtl/acc_seq_datapath.sv
module acc_seq_datapath
  import acc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] ir,
  output logic              iFlag,
  output logic              acSign,
  output logic              acZero,
  output logic              eVal,
  output logic              drZero,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ac
);
  logic [ADDR_W-1:0] ar;
  logic [DATA_W-1:0] dr;
  logic [DATA_W:0]   sumExt;

  assign memAddr = ar;
  assign acSign  = ac[DATA_W-1];
  assign acZero  = (ac == '0);
  assign drZero  = (dr == '0);
  assign sumExt  = {1'b0, ac} + {1'b0, dr};

  always_comb begin
    unique case (strb.wSrc)
      WSRC_PC: memWdata = DATA_W'(pc);
      WSRC_DR: memWdata = dr;
      default: memWdata = ac;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0; ar <= '0; ir <= '0; dr <= '0;
      ac <= '0; eVal <= 1'b0; iFlag <= 1'b0;
    end else begin
      if (strb.arFromPc)       ar <= pc;
      else if (strb.arFromIr)  ar <= ir[ADDR_W-1:0];
      else if (strb.arFromMem) ar <= memRdata[ADDR_W-1:0];
      else if (strb.arInc)     ar <= ar + 1'b1;

      if (strb.pcFromAr)   pc <= ar;
      else if (strb.pcInc) pc <= pc + 1'b1;

      if (strb.irLoad) ir <= memRdata;
      if (strb.iLoad)  iFlag <= ir[IND_B];

      if (strb.drLoad)     dr <= memRdata;
      else if (strb.drInc) dr <= dr + 1'b1;

      if (strb.acClr)         ac <= '0;
      else if (strb.acCmp)    ac <= ~ac;
      else if (strb.acShr)    ac <= {eVal, ac[DATA_W-1:1]};
      else if (strb.acShl)    ac <= {ac[DATA_W-2:0], eVal};
      else if (strb.acInc)    ac <= ac + 1'b1;
      else if (strb.acAnd)    ac <= ac & dr;
      else if (strb.acAdd)    ac <= sumExt[DATA_W-1:0];
      else if (strb.acFromDr) ac <= dr;

      if (strb.eClr)       eVal <= 1'b0;
      else if (strb.eCmp)  eVal <= ~eVal;
      else if (strb.acShr) eVal <= ac[0];
      else if (strb.acShl) eVal <= ac[DATA_W-1];
      else if (strb.acAdd) eVal <= sumExt[DATA_W];
    end
  end

  // R2: PC moves only on a fetch increment, skip or jump strobe
  p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.pcInc || strb.pcFromAr) |=> $stable(pc));
  // R4: AC holds unless an accumulator operation is strobed
  p_ac_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.acClr || strb.acCmp || strb.acShr || strb.acShl || strb.acInc ||
      strb.acAnd || strb.acAdd || strb.acFromDr) |=> $stable(ac));
  // R8: E holds unless an E-affecting operation is strobed
  p_e_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.eClr || strb.eCmp || strb.acShr || strb.acShl || strb.acAdd)
    |=> $stable(eVal));
endmodule

// File: rtl/acc_sequencer.sv
module acc_sequencer
  import acc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic [DATA_W-1:0] accValue,
  output logic [ADDR_W-1:0] pcValue,
  output logic              eFlag,
  output logic              running
);
  strobe_t           strb;
  logic [DATA_W-1:0] ir;
  logic              iFlag, acSign, acZero, drZero;

  acc_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ir(ir), .iFlag(iFlag), .acSign(acSign),
    .acZero(acZero), .eVal(eFlag), .drZero(drZero), .strb(strb),
    .running(running)
  );

  acc_seq_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .ir(ir), .iFlag(iFlag),
    .acSign(acSign), .acZero(acZero), .eVal(eFlag), .drZero(drZero),
    .pc(pcValue), .ac(accValue)
  );

  assign memWe = strb.memWe;
endmodule

// File: tb/tb_acc_sequencer.sv
`timescale 1ns/1ps
module tb_acc_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] memRdata, memWdata, accValue;
  logic [11:0] memAddr, pcValue;
  logic        memWe, eFlag, running;
  logic [15:0] mem [0:4095];

  int checks = 0, failures = 0;
  int qa[$], qd[$];
  string qt[$];

  always #2.5 clk = ~clk;

  acc_sequencer dut (
    .clk(clk), .rst_n(rst_n), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .memWe(memWe), .accValue(accValue),
    .pcValue(pcValue), .eFlag(eFlag), .running(running)
  );

  assign memRdata = mem[memAddr];
  always @(posedge clk) if (memWe) mem[memAddr] <= memWdata;

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic expectWrite(input string tag, input int a, input int d);
    qa.push_back(a); qd.push_back(d); qt.push_back(tag);
  endtask

  // monitor: compare every write against the scoreboard
  always @(negedge clk) begin
    if (rst_n && memWe) begin
      if (qa.size() == 0) begin
        check("R10", int'(memAddr), -1, "unexpected write address");
      end else begin
        string t;
        int a, d;
        a = qa.pop_front(); d = qd.pop_front(); t = qt.pop_front();
        check(t, int'(memAddr), a, "write address");
        check(t, int'(memWdata), d, "write data");
      end
    end
  end

  initial begin
    bit timedOut = 0;
    for (int i = 0; i < 4096; i++) mem[i] = 16'h7001;
    // program
    mem[0]  = 16'h2100; // LDA 100
    mem[1]  = 16'h1101; // ADD 101
    mem[2]  = 16'h3200; // STA 200
    mem[3]  = 16'h7100; // invert E
    mem[4]  = 16'h0102; // AND 102
    mem[5]  = 16'hB103; // STA indirect via 103
    mem[6]  = 16'h7100; // invert E
    mem[7]  = 16'h7080; // rotate right
    mem[8]  = 16'h3202;
    mem[9]  = 16'h7040; // rotate left
    mem[10] = 16'h7020; // increment
    mem[11] = 16'h3203;
    mem[12] = 16'h7200; // invert AC
    mem[13] = 16'h7008; // skip if negative
    mem[14] = 16'h7001;
    mem[15] = 16'h7010; // skip if positive (not taken)
    mem[16] = 16'h3204;
    mem[17] = 16'h7800; // clear AC
    mem[18] = 16'h7004; // skip if zero
    mem[19] = 16'h7001;
    mem[20] = 16'h7002; // skip if E zero (not taken, E=1)
    mem[21] = 16'h7400; // clear E
    mem[22] = 16'h7002; // skip if E zero
    mem[23] = 16'h7001;
    mem[24] = 16'h6105; // ISZ 105 -> zero, skip
    mem[25] = 16'h7001;
    mem[26] = 16'h6106; // ISZ 106 -> no skip
    mem[27] = 16'h3205;
    mem[28] = 16'hF800; // peripheral instruction
    mem[29] = 16'h5300; // BSA 300
    mem[12'h301] = 16'h3207;
    mem[12'h302] = 16'hC107; // BUN indirect via 107
    mem[32] = 16'h2108; // LDA 108
    mem[33] = 16'h7010; // skip if positive
    mem[34] = 16'h7001;
    mem[35] = 16'h3206;
    mem[36] = 16'h7001; // halt
    mem[12'h100] = 16'h1234;
    mem[12'h101] = 16'hF000;
    mem[12'h102] = 16'h00FF;
    mem[12'h103] = 16'h0201;
    mem[12'h105] = 16'hFFFF;
    mem[12'h106] = 16'h0005;
    mem[12'h107] = 16'h0020;
    mem[12'h108] = 16'h7777;

    // driver: expected writes in program order
    expectWrite("R4", 12'h200, 16'h0234); // LDA then ADD, carry into E
    expectWrite("R3", 12'h201, 16'h0034); // indirect store after AND
    expectWrite("R8", 12'h202, 16'h801A); // E=1 rotated into AC msb
    expectWrite("R8", 12'h203, 16'h0035); // rotate left then increment
    expectWrite("R9", 12'h204, 16'hFFCA); // negative skip taken, positive skip not
    expectWrite("R7", 12'h105, 16'h0000); // ISZ wraps to zero
    expectWrite("R7", 12'h106, 16'h0006); // ISZ no skip
    expectWrite("R7", 12'h205, 16'h0000); // slot after non-skipping ISZ runs
    expectWrite("R6", 12'h300, 16'h001E); // BSA return address
    expectWrite("R10", 12'h207, 16'h0000); // peripheral left AC untouched
    expectWrite("R9", 12'h206, 16'h7777); // positive skip taken

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(pcValue), 0, "reset pc");
    check("R1", int'(accValue), 0, "reset acc");
    check("R1", int'(eFlag), 0, "reset E");
    check("R1", int'(running), 1, "reset running");
    rst_n = 1'b1;

    for (int c = 0; c < 5000 && running; c++) @(negedge clk);
    if (running) begin
      timedOut = 1;
      check("R10", 0, 1, "watchdog: machine never halted");
    end
    if (!timedOut) begin
      check("R2", int'(pcValue), 12'h025, "pc after halt");
      check("R9", int'(accValue), 16'h7777, "final acc");
      check("R8", int'(eFlag), 0, "final E");
      repeat (20) @(negedge clk);
      check("R10", int'(pcValue), 12'h025, "pc frozen while halted");
      check("R10", int'(running), 0, "stays halted");
      check("R5", qa.size(), 0, "writes still outstanding");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule